// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Compares

This block is a free-running up-counter for an always-on, low-frequency clock domain. It keeps time while the rest of the chip sleeps. Two compare values raise sticky match flags as the count passes them. An option makes compare A the wrap point in place of the full-scale value, so the period becomes programmable. A debug qualifier decides whether counting freezes while a debugger holds the chip. Every flag is sticky, is cleared by a write-one pulse and is masked into a single interrupt line.

The control and compare inputs are expected to be already synchronised into the low-frequency domain. No bus, prescaler or clock selection is part of the block.

A small state machine sequences the counter. It has three states:
- `ST_IDLE`: the counter is disabled and held at zero.
- `ST_RUN`: the counter advances on every clock.
- `ST_PAUSE`: the counter is frozen by a debug halt.

It has these transitions:
- *arm*: `ST_IDLE` to `ST_RUN` when the enable is set.
- *halt*: `ST_RUN` to `ST_PAUSE` when a debug halt must stop the count.
- *resume*: `ST_PAUSE` to `ST_RUN` when the halt condition is gone.
- *disarm*: `ST_RUN` or `ST_PAUSE` to `ST_IDLE` when the enable is cleared.

In `ST_RUN` and `ST_PAUSE`, a clock edge on which the counter advances leaves the machine in `ST_RUN`. An edge on which it holds leaves it in `ST_PAUSE`.

Top module: `lp_tick_counter`

## Requirements
- R1: While `rst_n` is low, `count`, `flags` and `irq` are all zero.
- R2: The clock edge on which `run_en` is first seen high leaves `count` at zero. Each later edge with `run_en` high and no debug pause adds one to `count`.
- R3: An edge with `run_en` low sets `count` to zero and sets no flag. `count` stays zero while `run_en` is low. Flags that are already set keep their value. Enabling again restarts the count from zero, as in R2.
- R4: An advancing edge from the all-ones count sets `count` to zero and sets the wrap flag, which is `flags[2]`.
- R5: With `wrap_at_a` high, an advancing edge with `count == cmp_a` sets `count` to zero and sets `flags[2]`. With `wrap_at_a` high and `count` above `cmp_a`, counting continues up to all-ones. With `wrap_at_a` low, `cmp_a` has no effect on the wrap point.
- R6: `flags[0]` is set on an advancing edge that moves `count` onto `cmp_a`. `flags[1]` is set on an advancing edge that moves `count` onto `cmp_b`. A flag stays set until it is cleared.
- R7: While `dbg_halt` is high and `run_in_halt` is low, `count` holds its value. While `run_in_halt` is high, `dbg_halt` does not stop counting.
- R8: A high bit of `flag_clr` on an edge clears the matching flag. If the same edge also sets that flag, the set wins.
- R9: `irq` is high exactly when some bit is set in both `flags` and `irq_mask`. It follows the mask with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Low-frequency counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter enable |
| wrap_at_a | input | 1 | Wrap after `cmp_a` instead of all-ones |
| run_in_halt | input | 1 | Keep counting during debug halt |
| dbg_halt | input | 1 | Debug halt indication |
| cmp_a | input | CNT_W | Compare value A, which is also the optional wrap point |
| cmp_b | input | CNT_W | Compare value B |
| irq_mask | input | 3 | Interrupt enables; bit 0 is A, bit 1 is B, bit 2 is wrap |
| flag_clr | input | 3 | Write-one-to-clear pulses, with the same bit order as `irq_mask` |
| count | output | CNT_W | Current counter value |
| flags | output | 3 | Sticky event flags: bit 0 match A, bit 1 match B, bit 2 wrap |
| irq | output | 1 | OR of the flags under their enables |

## Verification
The embedded properties check the following on every cycle:
- A disabled counter is zero one edge later, and a disabled state machine returns to idle.
- An advancing edge adds exactly one, and a wrapping edge yields zero.
- A non-advancing, enabled edge leaves the count unchanged.
- No flag rises without a matching event, and a clear with no competing event empties the flag.

Only the bench scenarios can show the following:
- The true wrap points, both full-scale and compare A.
- Which edge a match lands on.
- The debug-halt qualifier.
- Restart from zero after re-enable.
- Set-over-clear priority.
- The combinational masking of the interrupt.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int NUM_CMP  = 2;
    localparam int FLAG_W   = NUM_CMP + 1;
    localparam int WRAP_BIT = NUM_CMP;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } run_state_e;
endpackage

// File: rtl/lpt_run_fsm.sv
module lpt_run_fsm
    import lpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic dbg_halt,
    input  logic run_in_halt,
    output logic adv,
    output logic zero
);
    run_state_e state_q, state_d;
    logic       pause_req;

    assign pause_req = dbg_halt && !run_in_halt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        adv     = 1'b0;
        zero    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                zero = 1'b1;
                if (run_en) state_d = ST_RUN;       // arm
            end
            ST_RUN, ST_PAUSE: begin
                if (!run_en) begin
                    zero    = 1'b1;
                    state_d = ST_IDLE;              // disarm
                end else if (pause_req) begin
                    state_d = ST_PAUSE;             // halt
                end else begin
                    adv     = 1'b1;
                    state_d = ST_RUN;               // resume / keep running
                end
            end
            default: begin
                zero    = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    // R3: a low enable always lands the machine in idle
    assert_off_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> state_q == ST_IDLE);
endmodule

// File: rtl/lpt_count_core.sv
module lpt_count_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             zero,
    input  logic             wrap_at_a,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             wrap_evt
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic at_wrap;

    assign at_wrap  = (wrap_at_a && (count == top_val)) || (count == FULL);
    assign nxt_cnt  = at_wrap ? '0 : count + ONE;
    assign wrap_evt = adv && at_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (zero) count <= '0;
        else if (adv)  count <= nxt_cnt;
    end

    assert_zero_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        zero |=> count == '0);
    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wrap_evt) |=> (count - $past(count)) == ONE);
    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> count == '0);
    assert_hold_when_paused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !zero) |=> $stable(count));
endmodule

// File: rtl/lpt_event_flags.sv
module lpt_event_flags
    import lpt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              wrap_evt,
    input  logic [CNT_W-1:0]  nxt_cnt,
    input  logic [CNT_W-1:0]  cmp_vals [NUM_CMP],
    input  logic [FLAG_W-1:0] flag_clr,
    input  logic [FLAG_W-1:0] irq_mask,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);
    logic [FLAG_W-1:0] set_vec;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_hit
        assign set_vec[i] = adv && (nxt_cnt == cmp_vals[i]);
    end
    assign set_vec[WRAP_BIT] = wrap_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | set_vec;
    end

    assign irq = |(flags & irq_mask);

    for (genvar j = 0; j < FLAG_W; j++) begin : g_chk
        // R6: a flag only rises after its own event
        assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[j]) |-> $past(set_vec[j]));
        // R8: a clear with no competing event empties the flag
        assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[j] && !set_vec[j]) |=> !flags[j]);
    end
endmodule

// File: rtl/lp_tick_counter.sv
module lp_tick_counter
    import lpt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk_lf,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             wrap_at_a,
    input  logic             run_in_halt,
    input  logic             dbg_halt,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [2:0]       irq_mask,
    input  logic [2:0]       flag_clr,
    output logic [CNT_W-1:0] count,
    output logic [2:0]       flags,
    output logic             irq
);
    logic             adv, zero, wrap_evt;
    logic [CNT_W-1:0] nxt_cnt;
    logic [CNT_W-1:0] cmp_vals [NUM_CMP];

    assign cmp_vals[0] = cmp_a;
    assign cmp_vals[1] = cmp_b;

    lpt_run_fsm u_fsm (
        .clk         (clk_lf),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .dbg_halt    (dbg_halt),
        .run_in_halt (run_in_halt),
        .adv         (adv),
        .zero        (zero)
    );

    lpt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk_lf),
        .rst_n     (rst_n),
        .adv       (adv),
        .zero      (zero),
        .wrap_at_a (wrap_at_a),
        .top_val   (cmp_a),
        .count     (count),
        .nxt_cnt   (nxt_cnt),
        .wrap_evt  (wrap_evt)
    );

    lpt_event_flags #(.CNT_W(CNT_W)) u_flags (
        .clk      (clk_lf),
        .rst_n    (rst_n),
        .adv      (adv),
        .wrap_evt (wrap_evt),
        .nxt_cnt  (nxt_cnt),
        .cmp_vals (cmp_vals),
        .flag_clr (flag_clr),
        .irq_mask (irq_mask),
        .flags    (flags),
        .irq      (irq)
    );
endmodule

// File: tb/tb_lp_tick_counter.sv
module tb_lp_tick_counter;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        en;
        logic        top;
        logic        drun;
        logic        halt;
        logic [2:0]  clr;
        logic [2:0]  mask;
        logic [23:0] cnt;
        logic [2:0]  flg;
        logic        irq;
        logic [3:0]  req;
    } vec_t;

    // cmp_a = 5, cmp_b = 3 throughout the table
    localparam vec_t VEC [22] = '{
        '{1'b1,1'b1,1'b0,1'b0,3'b000,3'b000,24'd0,3'b000,1'b0,4'd2}, // R2 arm
        '{1'b1,1'b1,1'b0,1'b0,3'b000,3'b000,24'd1,3'b000,1'b0,4'd2}, // R2
        '{1'b1,1'b1,1'b0,1'b0,3'b000,3'b000,24'd2,3'b000,1'b0,4'd2}, // R2
        '{1'b1,1'b1,1'b0,1'b0,3'b000,3'b000,24'd3,3'b010,1'b0,4'd6}, // R6 hit B
        '{1'b1,1'b1,1'b0,1'b0,3'b000,3'b010,24'd4,3'b010,1'b1,4'd9}, // R9
        '{1'b1,1'b1,1'b0,1'b0,3'b000,3'b010,24'd5,3'b011,1'b1,4'd6}, // R6 hit A
        '{1'b1,1'b1,1'b0,1'b0,3'b000,3'b100,24'd0,3'b111,1'b1,4'd5}, // R5 wrap at A
        '{1'b1,1'b1,1'b0,1'b0,3'b111,3'b111,24'd1,3'b000,1'b0,4'd8}, // R8 clear all
        '{1'b1,1'b1,1'b0,1'b1,3'b000,3'b111,24'd1,3'b000,1'b0,4'd7}, // R7 paused
        '{1'b1,1'b1,1'b1,1'b1,3'b000,3'b111,24'd2,3'b000,1'b0,4'd7}, // R7 runs in halt
        '{1'b1,1'b1,1'b0,1'b1,3'b000,3'b111,24'd2,3'b000,1'b0,4'd7}, // R7 paused
        '{1'b1,1'b1,1'b0,1'b0,3'b000,3'b000,24'd3,3'b010,1'b0,4'd6}, // R6 resume
        '{1'b0,1'b1,1'b0,1'b0,3'b000,3'b000,24'd0,3'b010,1'b0,4'd3}, // R3 disarm
        '{1'b0,1'b1,1'b0,1'b0,3'b000,3'b000,24'd0,3'b010,1'b0,4'd3}, // R3 held
        '{1'b1,1'b1,1'b0,1'b0,3'b010,3'b000,24'd0,3'b000,1'b0,4'd3}, // R3 rearm
        '{1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,24'd1,3'b000,1'b0,4'd3}, // R3 from zero
        '{1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,24'd2,3'b000,1'b0,4'd2}, // R2
        '{1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,24'd3,3'b010,1'b0,4'd6}, // R6
        '{1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,24'd4,3'b010,1'b0,4'd2}, // R2
        '{1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,24'd5,3'b011,1'b0,4'd6}, // R6
        '{1'b1,1'b0,1'b0,1'b0,3'b000,3'b000,24'd6,3'b011,1'b0,4'd5}, // R5 no wrap
        '{1'b1,1'b0,1'b0,1'b0,3'b001,3'b001,24'd7,3'b010,1'b0,4'd8}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, wrap_at_a = 1'b0, run_in_halt = 1'b0, dbg_halt = 1'b0;
    logic [23:0] cmp_a = 24'd5, cmp_b = 24'd3;
    logic [2:0]  irq_mask = 3'b000, flag_clr = 3'b000;
    logic [23:0] count;
    logic [2:0]  flags;
    logic        irq;

    logic        w_en = 1'b0;
    logic [7:0]  w_count;
    logic [2:0]  w_flags;
    logic        w_irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_tick_counter dut (
        .clk_lf(clk), .rst_n(rst_n), .run_en(run_en), .wrap_at_a(wrap_at_a),
        .run_in_halt(run_in_halt), .dbg_halt(dbg_halt), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .irq_mask(irq_mask), .flag_clr(flag_clr), .count(count), .flags(flags), .irq(irq)
    );

    // narrow copy used to reach the full-scale wrap quickly
    lp_tick_counter #(.CNT_W(8)) dut_w8 (
        .clk_lf(clk), .rst_n(rst_n), .run_en(w_en), .wrap_at_a(1'b0),
        .run_in_halt(1'b0), .dbg_halt(1'b0), .cmp_a(8'd200), .cmp_b(8'd100),
        .irq_mask(3'b100), .flag_clr(3'b000), .count(w_count), .flags(w_flags), .irq(w_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 count in reset", 32'(count), 0);
        chk("R1 flags in reset", 32'(flags), 0);
        chk("R1 irq in reset", 32'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            @(negedge clk);
            run_en = VEC[i].en; wrap_at_a = VEC[i].top; run_in_halt = VEC[i].drun;
            dbg_halt = VEC[i].halt; flag_clr = VEC[i].clr; irq_mask = VEC[i].mask;
            tick();
            chk($sformatf("R%0d vec %0d count", VEC[i].req, i), 32'(count), 32'(VEC[i].cnt));
            chk($sformatf("R%0d vec %0d flags", VEC[i].req, i), 32'(flags), 32'(VEC[i].flg));
            chk($sformatf("R%0d vec %0d irq", VEC[i].req, i), 32'(irq), 32'(VEC[i].irq));
        end

        // R5: count 7 already above cmp_a=5, turning on wrap_at_a keeps counting up
        @(negedge clk);
        flag_clr = 3'b000; irq_mask = 3'b000; wrap_at_a = 1'b1;
        tick();
        chk("R5 above compare continues", 32'(count), 8);
        chk("R5 no wrap flag", 32'(flags), 32'b010);

        // R9: mask acts with no clock
        @(negedge clk);
        run_en = 1'b0;
        irq_mask = 3'b010;
        #1 chk("R9 irq masked on", 32'(irq), 1);
        irq_mask = 3'b101;
        #1 chk("R9 irq masked off", 32'(irq), 0);

        // R1: asynchronous reset mid-run
        irq_mask = 3'b111;
        rst_n = 1'b0;
        #1;
        chk("R1 count after reset", 32'(count), 0);
        chk("R1 flags after reset", 32'(flags), 0);
        chk("R1 irq after reset", 32'(irq), 0);

        // R8: set beats clear on the same edge
        @(negedge clk);
        rst_n = 1'b1; run_en = 1'b1; wrap_at_a = 1'b1;
        tick();
        tick();
        tick();
        @(negedge clk);
        flag_clr = 3'b010;
        tick();
        chk("R8 set wins count", 32'(count), 3);
        chk("R8 set wins over clear", 32'(flags), 32'b010);
        tick();
        chk("R8 plain clear", 32'(flags), 32'b000);

        // R4: full-scale wrap on the 8-bit copy
        @(negedge clk);
        flag_clr = 3'b000;
        w_en = 1'b1;
        tick();
        chk("R4 arm at zero", 32'(w_count), 0);
        repeat (255) tick();
        chk("R4 at all-ones", 32'(w_count), 255);
        chk("R4 no wrap flag yet", 32'(w_flags[2]), 0);
        tick();
        chk("R4 wrapped to zero", 32'(w_count), 0);
        chk("R4 wrap flag set", 32'(w_flags[2]), 1);
        chk("R4 wrap irq", 32'(w_irq), 1);

        finish_run();
    end
endmodule